// File: doc/BRIEF.md
# Serial Command/Data Receiver

This block is the write-only serial front end of a display controller. A host selects the receiver and shifts bytes in most significant bit first. Each byte is captured on rising edges of a serial clock. A companion select line, sampled once per byte, tags the byte as pixel data or as a command. Each finished byte leaves the block as a parallel word with a one-cycle strobe and a data/command flag, for a command decoder or a display-memory writer downstream.

The serial pins are oversampled by a faster system clock. Every pin passes through a two-flop synchroniser, and serial clock edges are found from the synchronised samples. Two chip-select inputs of opposite polarity must both be asserted for the receiver to be active. Whenever they are not, the bit counter and the shift register stay cleared, so a new selection always starts on a fresh byte. No read path exists.

Top module: `serial_byte_rx`

## Requirements
- R1: The receiver is active only while selN is 0 and selP is 1. With selN=0,selP=0 or selN=1,selP=1, serial clock edges produce no byte strobe.
- R2: On each rising serClk edge while active, serDat is captured. The first bit of a byte lands in byteData[7] and the eighth in byteData[0].
- R3: On the eighth rising edge of a byte, byteValid is high for exactly one system clock cycle and never for two cycles in a row.
- R4: isData takes the dcSel value present at the eighth rising edge: 1 means display data and 0 means command. dcSel values at the other seven edges have no effect.
- R5: While the receiver is inactive, the bit count and the shift register are cleared. A partial byte cut off by deselection produces no strobe, and the next selection starts a new byte.
- R6: After the eighth edge the bit count returns to zero, so consecutive bytes stream without deselection, each with its own strobe.
- R7: After reset, byteValid, byteData and isData are all 0. byteData and isData change only in the cycle where byteValid is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Chip select, asserted low |
| selP | input | 1 | Chip select, asserted high |
| serClk | input | 1 | Serial shift clock, bits taken on its rising edge |
| serDat | input | 1 | Serial data, most significant bit first |
| dcSel | input | 1 | Data/command select: 1 display data, 0 command |
| byteValid | output | 1 | One-cycle strobe for a completed byte |
| byteData | output | 8 | Last completed byte |
| isData | output | 1 | Flag of the last completed byte: 1 data, 0 command |

## Verification
The assertions assume that each serial clock level lasts at least two system clock cycles, so that every rising edge is seen once after synchronisation. They also assume that serDat and dcSel are steady around each rising edge, and that the select lines do not change within a couple of cycles of a serial clock edge. The stimulus holds every serial clock phase for four system cycles and changes data, flag and selects only while the serial clock is low. dcSel is driven to the inverse of its final value on the first seven bits, so a receiver that samples it at the wrong edge shows a wrong flag.

// File: rtl/rx_pkg.sv
package rx_pkg;
  parameter int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W);

  // strobes from control to datapath
  typedef struct packed {
    logic clear;  // receiver idle: hold shifter at zero
    logic shift;  // take one serial bit
    logic load;   // final bit: publish the byte
  } rxStrobe_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= RST_VAL;
      syncOut <= RST_VAL;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       selNS,
  input  logic       selPS,
  output rxStrobe_t  strb
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic             sclPrev;
  logic             active;
  logic             sclRise;
  logic [CNT_W-1:0] bitCnt;

  assign active  = ~selNS & selPS;
  assign sclRise = sclS & ~sclPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b0;
      bitCnt  <= '0;
    end else begin
      sclPrev <= sclS;
      if (!active)
        bitCnt <= '0;
      else if (sclRise)
        bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strb.clear = ~active;
    strb.shift = active & sclRise;
    strb.load  = active & sclRise & (bitCnt == LAST);
  end

  AST_IDLE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> bitCnt == '0) else $error("count not cleared while idle"); // R5
  AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (active && sclRise && bitCnt != LAST) |=> bitCnt == $past(bitCnt) + CNT_W'(1))
    else $error("bit count did not advance"); // R2
  AST_COUNT_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (active && sclRise && bitCnt == LAST) |=> bitCnt == '0)
    else $error("bit count did not wrap"); // R6
endmodule

// File: rtl/rx_dpath.sv
module rx_dpath
  import rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              datS,
  input  logic              dcS,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              isData
);
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] nextWord;

  assign nextWord = {shReg[BYTE_W-2:0], datS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      isData    <= 1'b0;
    end else begin
      byteValid <= strb.load;
      if (strb.clear)
        shReg <= '0;
      else if (strb.shift)
        shReg <= nextWord;
      if (strb.load) begin
        byteData <= nextWord;
        isData   <= dcS;
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid) else $error("strobe wider than one cycle"); // R3
  AST_SHIFTER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> shReg == '0) else $error("shifter not cleared"); // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> $stable(byteData)) else $error("byte changed without strobe"); // R7
  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> $stable(isData)) else $error("flag changed without strobe"); // R4
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       selP,
  input  logic       serClk,
  input  logic       serDat,
  input  logic       dcSel,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       isData
);
  logic [4:0] syncd;
  rxStrobe_t  strb;

  // bit order: serClk, serDat, dcSel, selN, selP; selN resets deasserted
  rx_sync #(.W(5), .RST_VAL(5'b00010)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({serClk, serDat, dcSel, selN, selP}),
    .syncOut (syncd)
  );

  rx_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclS  (syncd[4]),
    .selNS (syncd[1]),
    .selPS (syncd[0]),
    .strb  (strb)
  );

  rx_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .datS      (syncd[3]),
    .dcS       (syncd[2]),
    .byteValid (byteValid),
    .byteData  (byteData),
    .isData    (isData)
  );
endmodule

// File: tb/serial_byte_rx_bench.sv
module serial_byte_rx_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, selP = 1'b0, serClk = 1'b0, serDat = 1'b0, dcSel = 1'b0;
  logic byteValid;
  logic [7:0] byteData;
  logic isData;

  int checks = 0;
  int errors = 0;
  int capCnt = 0;
  int widthErr = 0;
  logic [7:0] capData [64];
  logic       capFlag [64];
  logic       prevValid = 1'b0;

  // {flag, byte}
  localparam logic [8:0] VEC [8] = '{9'h1A5, 9'h03C, 9'h100, 9'h0FF,
                                     9'h181, 9'h07E, 9'h1FF, 9'h000};

  always #2 clk = ~clk;

  serial_byte_rx u_serial_byte_rx (
    .clk(clk), .rstN(rstN), .selN(selN), .selP(selP), .serClk(serClk),
    .serDat(serDat), .dcSel(dcSel), .byteValid(byteValid),
    .byteData(byteData), .isData(isData)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid && capCnt < 64) begin
        capData[capCnt] = byteData;
        capFlag[capCnt] = isData;
        capCnt++;
      end
      if (byteValid && prevValid) widthErr++;
      prevValid = byteValid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input logic dc);
    @(negedge clk);
    serClk = 1'b0; serDat = b; dcSel = dc;
    waitN(4);
    serClk = 1'b1;
    waitN(4);
    serClk = 1'b0;
  endtask

  // earlier bits carry the inverse flag so only the last one may count
  task automatic sendByte(input logic [7:0] v, input logic dc);
    for (int i = 7; i >= 0; i--) sendBit(v[i], (i == 0) ? dc : ~dc);
    waitN(6);
  endtask

  task automatic setSel(input logic n, input logic p);
    @(negedge clk);
    selN = n; selP = p;
    waitN(4);
  endtask

  task automatic checkByte(input int idx, input logic [7:0] v, input logic dc, input string req);
    check(capData[idx] == v, req, capData[idx], v);
    check(capFlag[idx] == dc, {req, "_flag"}, capFlag[idx], dc);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    waitN(3);
    // R7: reset state
    check(byteValid == 1'b0, "R7_valid", byteValid, 0);
    check(byteData == 8'h00, "R7_data", byteData, 0);
    check(isData == 1'b0, "R7_flag", isData, 0);
    rstN = 1'b1;
    waitN(4);

    // R2 R3 R4: table walk, one selection per byte
    foreach (VEC[k]) begin
      base = capCnt;
      setSel(1'b0, 1'b1);
      sendByte(VEC[k][7:0], VEC[k][8]);
      setSel(1'b1, 1'b0);
      check(capCnt == base + 1, "R3_count", capCnt - base, 1);
      checkByte(base, VEC[k][7:0], VEC[k][8], "R2");
    end

    // R1: both selects low, then both high
    base = capCnt;
    setSel(1'b0, 1'b0);
    sendByte(8'hC3, 1'b1);
    check(capCnt == base, "R1_both_low", capCnt - base, 0);
    setSel(1'b1, 1'b1);
    sendByte(8'h3C, 1'b0);
    check(capCnt == base, "R1_both_high", capCnt - base, 0);
    setSel(1'b1, 1'b0);

    // R5: partial byte then deselect, fresh byte afterwards
    base = capCnt;
    setSel(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) sendBit(1'b1, 1'b1);
    waitN(6);
    setSel(1'b1, 1'b0);
    check(capCnt == base, "R5_no_strobe", capCnt - base, 0);
    setSel(1'b0, 1'b1);
    sendByte(8'h5A, 1'b0);
    setSel(1'b1, 1'b0);
    check(capCnt == base + 1, "R5_count", capCnt - base, 1);
    checkByte(base, 8'h5A, 1'b0, "R5");

    // R6: back-to-back stream
    base = capCnt;
    setSel(1'b0, 1'b1);
    sendByte(8'h12, 1'b0);
    sendByte(8'hEF, 1'b1);
    sendByte(8'h80, 1'b0);
    setSel(1'b1, 1'b0);
    check(capCnt == base + 3, "R6_count", capCnt - base, 3);
    checkByte(base, 8'h12, 1'b0, "R6_b0");
    checkByte(base + 1, 8'hEF, 1'b1, "R6_b1");
    checkByte(base + 2, 8'h80, 1'b0, "R6_b2");

    // R3: strobe never two cycles wide
    check(widthErr == 0, "R3_width", widthErr, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule